// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block finds the pressed key on a switch matrix of rows and columns. The row lines are outputs and the column lines are inputs. Both are active low, and the column lines are pulled up outside the block. A pressed key connects its row to its column, so the column reads low only while that row is driven low.

The scanner searches in two phases. While idle, it drives every row low at once and watches the columns. When a column reads low steadily, the scanner knows which column holds the key. It then drives one row low at a time, in ascending order, until that column goes low again, and this gives the row. It reports the row, the column and a flat key code with a one-cycle strobe. It then waits until every column reads high before it searches again.

The column inputs pass through a two-flop synchroniser. Each new row pattern is held for `SETTLE` clocks before the columns are judged. `SETTLE` must be at least 3 so that the synchroniser reflects the new drive. Only the first hit in scan order is reported.

Top module: `kpd_scanner`

## Requirements
- R1: During reset and in the first cycle after it, all row outputs are low, the strobe is low, and the row, column and code outputs are zero.
- R2: While no key is pressed, all rows stay driven low and no strobe is issued.
- R3: Row outputs are either all low or exactly one low. While a single row is driven low, the rows step in ascending order starting at row 0.
- R4: A held key at row r and column c produces a strobe one clock wide with `key_row_o` = r, `key_col_o` = c and `key_code_o` = r*COLS + c.
- R5: A column low that lasts fewer than `DEBOUNCE` consecutive settled samples in the all-rows-low phase is not reported.
- R6: A key held for a long time gives exactly one strobe. After all columns have read high for `DEBOUNCE` samples, the rows return to all low and a new press is reported again.
- R7: If several keys are pressed, the lowest column index that reads low is chosen. Within that column, the lowest row index is chosen.
- R8: If the key is released after the single-row phase has begun, so that no row matches, no strobe is issued and the rows return to all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_n_i | input | COLS | Column sense lines, active low, pulled up |
| row_n_o | output | ROWS | Row drive lines, active low |
| key_valid_o | output | 1 | One-cycle strobe for a located key |
| key_row_o | output | idx_w(ROWS) | Row index of the last reported key |
| key_col_o | output | idx_w(COLS) | Column index of the last reported key |
| key_code_o | output | idx_w(ROWS*COLS) | Row index times COLS plus column index |

## Verification
Two events can land in the same cycle: the release of a key, and the settled sample in the single-row phase that would have matched it. The bench provokes this by releasing the key as soon as the row outputs leave the all-low pattern. It judges the result by seeing no strobe and by seeing the rows return to all low. A second collision is a press that is too short for the debounce count to fill. The bench provokes it with a two-clock press and expects silence. A bench model of the matrix pulls a column low from the live row drive, so wrong row or column selection shows up at the ports.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_DETECT  = 2'd0,
        ST_LOCATE  = 2'd1,
        ST_RELEASE = 2'd2
    } scan_state_e;

    // Index width for n items, never below one bit
    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Flat key number from row and column
    function automatic int flat_index(input int r, input int c, input int ncols);
        return r * ncols + c;
    endfunction

endpackage

// File: rtl/kpd_col_sync.sv
module kpd_col_sync
    import kpd_pkg::*;
#(
    parameter int W      = 4,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '1;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/kpd_row_drv.sv
module kpd_row_drv
    import kpd_pkg::*;
#(
    parameter int ROWS = 4,
    localparam int RW  = idx_w(ROWS)
) (
    input  logic            all_low_i,
    input  logic [RW-1:0]   row_sel_i,
    output logic [ROWS-1:0] row_n_o
);

    genvar g;
    generate
        for (g = 0; g < ROWS; g++) begin : g_row
            assign row_n_o[g] = !(all_low_i || (row_sel_i == RW'(g)));
        end
    endgenerate

endmodule

// File: rtl/kpd_ctrl.sv
module kpd_ctrl
    import kpd_pkg::*;
#(
    parameter int ROWS     = 4,
    parameter int COLS     = 4,
    parameter int SETTLE   = 4,
    parameter int DEBOUNCE = 3,
    localparam int RW = idx_w(ROWS),
    localparam int CW = idx_w(COLS),
    localparam int KW = idx_w(ROWS * COLS),
    localparam int SW = idx_w(SETTLE),
    localparam int DW = idx_w(DEBOUNCE + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [COLS-1:0] cs_i,
    output logic            all_low_o,
    output logic [RW-1:0]   row_sel_o,
    output logic            key_valid_o,
    output logic [RW-1:0]   key_row_o,
    output logic [CW-1:0]   key_col_o,
    output logic [KW-1:0]   key_code_o
);

    scan_state_e      state_q;
    logic [SW-1:0]    settle_q;
    logic [DW-1:0]    deb_q;
    logic [DW-1:0]    deb_nxt;
    logic [COLS-1:0]  prev_q;
    logic [CW-1:0]    col_q;
    logic [RW-1:0]    row_q;
    logic [CW-1:0]    lo_idx;
    logic             settled;
    logic             any_low;
    logic             col_hit;

    assign settled = (settle_q == SW'(SETTLE - 1));
    assign any_low = ~&cs_i;
    assign col_hit = !cs_i[col_q];

    // Lowest-index low column wins
    always_comb begin
        lo_idx = '0;
        for (int i = COLS - 1; i >= 0; i--) begin
            if (!cs_i[i]) lo_idx = CW'(i);
        end
    end

    // Consecutive-sample counter for press (detect) or full release
    always_comb begin
        deb_nxt = '0;
        if (state_q == ST_RELEASE) begin
            deb_nxt = any_low ? '0 : deb_q + 1'b1;
        end else if (any_low) begin
            deb_nxt = ((cs_i == prev_q) && (deb_q != '0)) ? deb_q + 1'b1 : DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_DETECT;
            settle_q   <= '0;
            deb_q      <= '0;
            prev_q     <= '1;
            col_q      <= '0;
            row_q      <= '0;
            key_valid_o <= 1'b0;
            key_row_o  <= '0;
            key_col_o  <= '0;
            key_code_o <= '0;
        end else begin
            key_valid_o <= 1'b0;
            if (!settled) settle_q <= settle_q + 1'b1;
            unique case (state_q)
                ST_DETECT: begin
                    if (settled) begin
                        prev_q <= cs_i;
                        deb_q  <= deb_nxt;
                        if (deb_nxt == DW'(DEBOUNCE)) begin
                            col_q    <= lo_idx;
                            row_q    <= '0;
                            deb_q    <= '0;
                            settle_q <= '0;
                            state_q  <= ST_LOCATE;
                        end
                    end
                end
                ST_LOCATE: begin
                    if (settled) begin
                        settle_q <= '0;
                        if (col_hit) begin
                            key_valid_o <= 1'b1;
                            key_row_o   <= row_q;
                            key_col_o   <= col_q;
                            key_code_o  <= KW'(flat_index(int'(row_q), int'(col_q), COLS));
                            state_q     <= ST_RELEASE;
                        end else if (row_q == RW'(ROWS - 1)) begin
                            row_q   <= '0;
                            prev_q  <= '1;
                            state_q <= ST_DETECT;
                        end else begin
                            row_q <= row_q + 1'b1;
                        end
                    end
                end
                ST_RELEASE: begin
                    if (settled) begin
                        deb_q <= deb_nxt;
                        if (deb_nxt == DW'(DEBOUNCE)) begin
                            deb_q    <= '0;
                            prev_q   <= '1;
                            settle_q <= '0;
                            state_q  <= ST_DETECT;
                        end
                    end
                end
                default: state_q <= ST_DETECT;
            endcase
        end
    end

    assign all_low_o = (state_q != ST_LOCATE);
    assign row_sel_o = row_q;

    // R2: the search phase never emits a strobe in the following cycle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DETECT) |=> !key_valid_o);

    // R4: strobe lasts a single clock
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        key_valid_o |=> !key_valid_o);

    // R4: a strobe only follows the single-row phase
    a_r4_from_locate: assert property (@(posedge clk) disable iff (rst)
        key_valid_o |-> ($past(state_q) == ST_LOCATE));

    // R4: reported row lies inside the matrix
    a_r4_row_range: assert property (@(posedge clk) disable iff (rst)
        key_valid_o |-> (int'(key_row_o) < ROWS));

    // R6: no repeat strobe while waiting for release
    a_r6_release_quiet: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_RELEASE) && ($past(state_q) == ST_RELEASE)) |-> !key_valid_o);

endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner
    import kpd_pkg::*;
#(
    parameter int ROWS     = 4,
    parameter int COLS     = 4,
    parameter int SETTLE   = 4,
    parameter int DEBOUNCE = 3,
    localparam int RW = idx_w(ROWS),
    localparam int CW = idx_w(COLS),
    localparam int KW = idx_w(ROWS * COLS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [COLS-1:0] col_n_i,
    output logic [ROWS-1:0] row_n_o,
    output logic            key_valid_o,
    output logic [RW-1:0]   key_row_o,
    output logic [CW-1:0]   key_col_o,
    output logic [KW-1:0]   key_code_o
);

    logic [COLS-1:0] col_s;
    logic            all_low;
    logic [RW-1:0]   row_sel;

    kpd_col_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (col_n_i),
        .q_o (col_s)
    );

    kpd_ctrl #(
        .ROWS(ROWS), .COLS(COLS), .SETTLE(SETTLE), .DEBOUNCE(DEBOUNCE)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cs_i        (col_s),
        .all_low_o   (all_low),
        .row_sel_o   (row_sel),
        .key_valid_o (key_valid_o),
        .key_row_o   (key_row_o),
        .key_col_o   (key_col_o),
        .key_code_o  (key_code_o)
    );

    kpd_row_drv #(.ROWS(ROWS)) u_rows (
        .all_low_i (all_low),
        .row_sel_i (row_sel),
        .row_n_o   (row_n_o)
    );

    // R3: rows are all low or exactly one low
    a_r3_rows_legal: assert property (@(posedge clk) disable iff (rst)
        (row_n_o == '0) || ($countones(~row_n_o) == 1));

    // R4: a strobe coincides with the single-row drive being released
    a_r4_one_row_before: assert property (@(posedge clk) disable iff (rst)
        key_valid_o |-> ($countones(~$past(row_n_o)) == 1));

endmodule

// File: tb/sim_kpd_scanner.sv
`timescale 1ns/1ps
module sim_kpd_scanner;

    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int N_VEC = 6;
    localparam logic [7:0] VEC [N_VEC] = '{8'h00, 8'h33, 8'h12, 8'h20, 8'h03, 8'h31};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [COLS-1:0] col_n;
    logic [ROWS-1:0] row_n;
    logic            key_valid;
    logic [1:0]      key_row;
    logic [1:0]      key_col;
    logic [3:0]      key_code;
    logic [ROWS*COLS-1:0] press_map = '0;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int r3_bad = 0;
    int r3_seen = 0;
    int prev_idx = -1;

    always #2 clk = ~clk;

    kpd_scanner #(.ROWS(ROWS), .COLS(COLS), .SETTLE(4), .DEBOUNCE(3)) u0 (
        .clk (clk), .rst (rst), .col_n_i (col_n), .row_n_o (row_n),
        .key_valid_o (key_valid), .key_row_o (key_row),
        .key_col_o (key_col), .key_code_o (key_code)
    );

    // Switch matrix model: a pressed key pulls its column low while its row is low
    always_comb begin
        col_n = '1;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (press_map[r*COLS+c] && !row_n[r]) col_n[c] = 1'b0;
            end
        end
    end

    // Strobe counter and row-order monitor
    always @(negedge clk) begin
        if (!rst) begin
            int idx;
            if (key_valid) pulses++;
            idx = -1;
            if ($countones(~row_n) == 1) begin
                for (int r = 0; r < ROWS; r++) if (!row_n[r]) idx = r;
                r3_seen++;
                if (prev_idx < 0 && idx != 0) r3_bad++;
                if (prev_idx >= 0 && idx != prev_idx && idx != prev_idx + 1) r3_bad++;
            end
            prev_idx = idx;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_strobe(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (key_valid) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic release_all();
        press_map = '0;
        cyc(40);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        int p0;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(row_n == '0, "R1 rows", row_n, 0);
        chk(key_valid == 1'b0, "R1 strobe", key_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(row_n == '0 && key_valid == 1'b0, "R1 first cycle", {row_n, key_valid}, 0);
        chk(key_code == 0 && key_row == 0 && key_col == 0, "R1 outputs", key_code, 0);

        // R2: idle
        cyc(50);
        chk(row_n == '0, "R2 idle rows", row_n, 0);
        chk(pulses == 0, "R2 idle strobes", pulses, 0);

        // R4/R6: table of single presses
        for (int v = 0; v < N_VEC; v++) begin
            int er;
            int ec;
            er = int'(VEC[v][7:4]);
            ec = int'(VEC[v][3:0]);
            p0 = pulses;
            press_map[er*COLS+ec] = 1'b1;
            wait_strobe(seen);
            chk(seen, "R4 strobe seen", seen, 1);
            chk(int'(key_row) == er, "R4 row", key_row, er);
            chk(int'(key_col) == ec, "R4 col", key_col, ec);
            chk(int'(key_code) == er*COLS + ec, "R4 code", key_code, er*COLS + ec);
            cyc(100);
            chk(pulses - p0 == 1, "R6 one strobe per press", pulses - p0, 1);
            release_all();
            chk(row_n == '0, "R6 rearmed rows", row_n, 0);
        end

        // R3: row ordering seen during all locates
        chk(r3_bad == 0, "R3 row order", r3_bad, 0);
        chk(r3_seen > 0, "R3 single rows seen", r3_seen, 1);

        // R5: press shorter than the debounce count
        p0 = pulses;
        press_map[0] = 1'b1;
        cyc(2);
        press_map[0] = 1'b0;
        cyc(60);
        chk(pulses == p0, "R5 short press ignored", pulses - p0, 0);
        chk(row_n == '0, "R5 rows idle", row_n, 0);

        // R7: two columns, lowest column wins
        press_map[2*COLS+1] = 1'b1;
        press_map[1*COLS+3] = 1'b1;
        wait_strobe(seen);
        chk(seen && key_row == 2 && key_col == 1, "R7 lowest column", {key_row, key_col}, 9);
        release_all();

        // R7: same column, lowest row wins
        press_map[3*COLS+2] = 1'b1;
        press_map[1*COLS+2] = 1'b1;
        wait_strobe(seen);
        chk(seen && key_row == 1 && key_col == 2, "R7 lowest row", {key_row, key_col}, 6);
        release_all();

        // R8: release once the single-row phase starts
        p0 = pulses;
        press_map[3*COLS+2] = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (row_n != '0) break;
        end
        press_map = '0;
        cyc(60);
        chk(pulses == p0, "R8 no strobe", pulses - p0, 0);
        chk(row_n == '0, "R8 back to all low", row_n, 0);

        // R6: a fresh press after the aborted one is still found
        press_map[1*COLS+1] = 1'b1;
        wait_strobe(seen);
        chk(seen && key_code == 5, "R6 press after abort", key_code, 5);
        release_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule